// File: doc/BRIEF.md
# Stream-to-Memory Burst Write Engine

This block moves a stream of data words into system memory as AXI4 write bursts. Software sets up a transfer over a narrow configuration port. It first writes a selection code that wakes the block, then writes the physical byte address where the data should land, and then writes the number of words. The engine splits the transfer into bursts of at most `BURST_LEN` beats. It issues one address phase per burst, sends the buffered stream words as write beats, and waits for each write response before it starts the next burst. When the response for the final burst arrives, a completion flag rises.

The upstream stream port is not a strict ready/valid handshake. Any cycle with `in_valid` high delivers a word, and the block must take it. `in_ready` only asks the source to stop soon. An internal FIFO holds the words that are still in flight. `in_ready` falls while `STOP_LAT` or more slots are still free, so the words that arrive after it falls always fit. Write response codes are accepted but not inspected.

Top module: `strm_burst_writer`

## Requirements
- R1: A configuration write takes effect only in order. First comes a write whose value equals `SEL_CODE` (default 0xA5). The next write is the base byte address, and the write after that is the word count, which launches the transfer. While the block waits for the selection code, any other value is ignored.
- R2: Every word presented with `in_valid` high is accepted, including words presented while `in_ready` is low. The words appear on `m_wdata` in arrival order.
- R3: `in_ready` is high exactly when the FIFO (default depth 16) has more than `STOP_LAT` (default 4) free entries. No word is lost when the source stops within `STOP_LAT` cycles.
- R4: Burst k of a transfer uses the address base + k × (DATA_W/8) × BURST_LEN. With the defaults this is base + 32·k.
- R5: `m_awlen` equals min(remaining words, BURST_LEN) − 1, so only the final burst may be shorter. `m_awsize` is log2(DATA_W/8), which is 3 by default. `m_awburst` is 2'b01 (incrementing). `m_wstrb` is all ones.
- R6: Each burst carries exactly `m_awlen`+1 write beats, and `m_wlast` is high only on the final beat.
- R7: Only one burst is in progress at a time. The next address phase starts only after the write response of the previous burst, and `m_awvalid` and `m_wvalid` are never high together.
- R8: While `m_awvalid` is high and `m_awready` is low, `m_awvalid`, `m_awaddr` and `m_awlen` hold their values.
- R9: `done` rises in the cycle after the write response handshake of the final burst. A new count write clears it. A count of zero sets `done` without any burst.
- R10: Configuration writes that arrive while a transfer is in progress are discarded and do not change the running transfer.
- R11: After reset, `done`, `m_awvalid`, `m_wvalid` and `m_bready` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_data | input | CFG_W | Configuration write value (selection code, address or count) |
| in_valid | input | 1 | Stream word present; always accepted |
| in_data | input | DATA_W | Stream word |
| in_ready | output | 1 | Advisory stop request to the source when low |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_awaddr | output | ADDR_W | Burst start byte address |
| m_awlen | output | 8 | Beats in burst minus one |
| m_awsize | output | 3 | Bytes per beat, log2 |
| m_awburst | output | 2 | Burst type, incrementing |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Byte strobes, all set |
| m_wlast | output | 1 | Final beat of the burst |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| done | output | 1 | Transfer complete |

## Verification
The bench drives a 20-word transfer against a write channel that accepts one beat in five. This fills the FIFO and keeps the source sending after `in_ready` falls. A design that dropped late words, or lowered ready too late, would lose or overwrite stream data. Word counts of 5, 3 and 1 create short final bursts. A design that always sent full-length bursts would report too many beats, and its later bursts would land on earlier data. A command issued during a running transfer, and stray writes without the selection code, must leave the burst addresses and lengths unchanged. A zero count must raise `done` without any address phase.

// File: rtl/strm_pkg.sv
// Shared types for the stream-to-memory burst write engine.
package strm_pkg;

    // Configuration sequencer position.
    typedef enum logic [1:0] {
        CFG_WAIT_SEL  = 2'd0,
        CFG_WAIT_ADDR = 2'd1,
        CFG_WAIT_CNT  = 2'd2
    } cfg_state_t;

    // Burst engine phase.
    typedef enum logic [1:0] {
        BW_IDLE = 2'd0,
        BW_ADDR = 2'd1,
        BW_DATA = 2'd2,
        BW_RESP = 2'd3
    } bw_state_t;

endpackage

// File: rtl/strm_cmd_capture.sv
// Command capture: walks the select / address / count sequence on the
// configuration port and emits a one-cycle start pulse with the command.
// Assumes busy_i covers the whole transfer, including the start cycle.
module strm_cmd_capture
    import strm_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter int          CNT_W    = 16,
    parameter int          CFG_W    = 32,
    parameter logic [31:0] SEL_CODE = 32'h0000_00A5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid_i,
    input  logic [CFG_W-1:0]  cfg_data_i,
    input  logic              busy_i,
    output logic              start_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CNT_W-1:0]  count_o
);

    localparam logic [CFG_W-1:0] SEL_VAL = CFG_W'(SEL_CODE);

    cfg_state_t       seq_q;
    logic             accept;

    // A write counts only while no transfer is in progress.
    assign accept = cfg_valid_i && !busy_i;

    // Sequencer: advance on accepted writes, fire start after the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q   <= CFG_WAIT_SEL;
            start_o <= 1'b0;
            addr_o  <= '0;
            count_o <= '0;
        end else begin
            start_o <= 1'b0;
            if (accept) begin
                case (seq_q)
                    CFG_WAIT_SEL: begin
                        if (cfg_data_i == SEL_VAL) seq_q <= CFG_WAIT_ADDR;
                    end
                    CFG_WAIT_ADDR: begin
                        addr_o <= cfg_data_i[ADDR_W-1:0];
                        seq_q  <= CFG_WAIT_CNT;
                    end
                    CFG_WAIT_CNT: begin
                        count_o <= cfg_data_i[CNT_W-1:0];
                        start_o <= 1'b1;
                        seq_q   <= CFG_WAIT_SEL;
                    end
                    default: seq_q <= CFG_WAIT_SEL;
                endcase
            end
        end
    end

    // R10: no new start is produced while the engine is busy.
    assert_no_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> !start_o);

endmodule

// File: rtl/strm_fifo.sv
// Absorbing FIFO: always stores an incoming word, and requests a stop
// upstream once free space drops to STOP_LAT entries.
// Assumes DEPTH is a power of two and the source stops within STOP_LAT cycles.
module strm_fifo #(
    parameter int WIDTH    = 64,
    parameter int DEPTH    = 16,
    parameter int STOP_LAT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] data_o,
    output logic             empty_o,
    output logic             ready_o
);

    localparam int             PTR_W      = $clog2(DEPTH);
    localparam logic [PTR_W:0] FULL_CNT   = (PTR_W+1)'(DEPTH);
    localparam logic [PTR_W:0] OPEN_LIMIT = (PTR_W+1)'(DEPTH - STOP_LAT);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [PTR_W:0]   fill_q;
    logic             full, do_push, do_pop;

    assign full    = (fill_q == FULL_CNT);
    assign empty_o = (fill_q == '0);
    assign do_push = push_i && !full;
    assign do_pop  = pop_i && !empty_o;
    assign ready_o = (fill_q < OPEN_LIMIT);
    assign data_o  = mem[rd_ptr_q];

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr_q] <= data_i;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            fill_q   <= '0;
        end else begin
            if (do_push) wr_ptr_q <= wr_ptr_q + 1'b1;
            if (do_pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   fill_q <= fill_q + 1'b1;
                2'b01:   fill_q <= fill_q - 1'b1;
                default: fill_q <= fill_q;
            endcase
        end
    end

    // R3: the stop threshold leaves room for every late word.
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full);

    // R3: ready only drops because a word was stored.
    assert_ready_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_o) |-> $past(push_i));

endmodule

// File: rtl/strm_burst_ctrl.sv
// Burst sequencer: splits a command into bursts of at most BURST_LEN beats,
// issues one address phase, the data beats and waits for the response,
// one burst at a time. Response codes are not inspected.
module strm_burst_ctrl
    import strm_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 16,
    parameter int DATA_W    = 64,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              fifo_empty_i,
    input  logic              awready_i,
    input  logic              wready_i,
    input  logic              bvalid_i,
    output logic              awvalid_o,
    output logic [ADDR_W-1:0] awaddr_o,
    output logic [7:0]        awlen_o,
    output logic              wvalid_o,
    output logic              wlast_o,
    output logic              bready_o,
    output logic              pop_o,
    output logic              done_o,
    output logic              idle_o
);

    localparam int                BYTES  = DATA_W / 8;
    localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(BYTES * BURST_LEN);
    localparam logic [CNT_W-1:0]  BL_W   = CNT_W'(BURST_LEN);

    bw_state_t         state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  remain_q;
    logic [7:0]        len_q, beat_q;
    logic              done_q;
    logic [CNT_W-1:0]  chunk;
    logic [CNT_W-1:0]  sent_words;

    // Words in the next burst: a full burst or what is left.
    always_comb chunk = (remain_q > BL_W) ? BL_W : remain_q;

    assign sent_words = CNT_W'(len_q) + CNT_W'(1);
    assign awvalid_o  = (state_q == BW_ADDR);
    assign awaddr_o   = addr_q;
    assign awlen_o    = 8'(chunk - CNT_W'(1));
    assign wvalid_o   = (state_q == BW_DATA) && !fifo_empty_i;
    assign wlast_o    = (state_q == BW_DATA) && (beat_q == len_q);
    assign pop_o      = wvalid_o && wready_i;
    assign bready_o   = (state_q == BW_RESP);
    assign done_o     = done_q;
    assign idle_o     = (state_q == BW_IDLE);

    // Phase sequencing, address stepping and completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= BW_IDLE;
            addr_q   <= '0;
            remain_q <= '0;
            len_q    <= '0;
            beat_q   <= '0;
            done_q   <= 1'b0;
        end else begin
            case (state_q)
                BW_IDLE: begin
                    if (start_i) begin
                        addr_q   <= base_i;
                        remain_q <= count_i;
                        done_q   <= (count_i == '0);
                        if (count_i != '0) state_q <= BW_ADDR;
                    end
                end
                BW_ADDR: begin
                    if (awready_i) begin
                        len_q   <= awlen_o;
                        beat_q  <= '0;
                        state_q <= BW_DATA;
                    end
                end
                BW_DATA: begin
                    if (pop_o) begin
                        if (wlast_o) state_q <= BW_RESP;
                        else         beat_q  <= beat_q + 1'b1;
                    end
                end
                BW_RESP: begin
                    if (bvalid_i) begin
                        remain_q <= remain_q - sent_words;
                        addr_q   <= addr_q + STEP_A;
                        if (remain_q == sent_words) begin
                            done_q  <= 1'b1;
                            state_q <= BW_IDLE;
                        end else begin
                            state_q <= BW_ADDR;
                        end
                    end
                end
                default: state_q <= BW_IDLE;
            endcase
        end
    end

    // R8: a stalled address phase holds its content.
    assert_aw_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        awvalid_o && !awready_i |=> awvalid_o && $stable(awaddr_o) && $stable(awlen_o));

    // R7: address and data phases never overlap.
    assert_one_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
        awvalid_o |-> !wvalid_o);

    // R5: a burst never claims more beats than the burst length.
    assert_len_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        awvalid_o |-> (awlen_o < 8'(BURST_LEN)));

    // R6: the final beat is followed by the response phase.
    assert_last_to_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wvalid_o && wready_i && wlast_o |=> bready_o);

    // R9: done rises only after a response or a zero-length command.
    assert_done_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(bvalid_i && bready_o) || $past(start_i));

    // R9: done clears only on a new command.
    assert_done_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_o) |-> $past(start_i));

endmodule

// File: rtl/strm_burst_writer.sv
// Top level: configuration capture, absorbing input FIFO and burst engine.
// Assumes the source honours in_ready within STOP_LAT cycles and that the
// memory side returns one write response per burst.
module strm_burst_writer #(
    parameter int          DATA_W     = 64,
    parameter int          ADDR_W     = 32,
    parameter int          CNT_W      = 16,
    parameter int          CFG_W      = 32,
    parameter int          BURST_LEN  = 4,
    parameter int          FIFO_DEPTH = 16,
    parameter int          STOP_LAT   = 4,
    parameter logic [31:0] SEL_CODE   = 32'h0000_00A5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_valid,
    input  logic [CFG_W-1:0]    cfg_data,
    input  logic                in_valid,
    input  logic [DATA_W-1:0]   in_data,
    output logic                in_ready,
    output logic                m_awvalid,
    input  logic                m_awready,
    output logic [ADDR_W-1:0]   m_awaddr,
    output logic [7:0]          m_awlen,
    output logic [2:0]          m_awsize,
    output logic [1:0]          m_awburst,
    output logic                m_wvalid,
    input  logic                m_wready,
    output logic [DATA_W-1:0]   m_wdata,
    output logic [DATA_W/8-1:0] m_wstrb,
    output logic                m_wlast,
    input  logic                m_bvalid,
    output logic                m_bready,
    output logic                done
);

    localparam int BYTES     = DATA_W / 8;
    localparam int SIZE_CODE = $clog2(BYTES);

    logic              cmd_start;
    logic [ADDR_W-1:0] cmd_addr;
    logic [CNT_W-1:0]  cmd_count;
    logic              eng_idle, busy;
    logic              fifo_empty, fifo_pop;

    assign busy      = !eng_idle || cmd_start;
    assign m_awsize  = 3'(SIZE_CODE);
    assign m_awburst = 2'b01;
    assign m_wstrb   = '1;

    strm_cmd_capture #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CFG_W(CFG_W), .SEL_CODE(SEL_CODE)
    ) u_cmd (
        .clk(clk), .rst_n(rst_n),
        .cfg_valid_i(cfg_valid), .cfg_data_i(cfg_data), .busy_i(busy),
        .start_o(cmd_start), .addr_o(cmd_addr), .count_o(cmd_count)
    );

    strm_fifo #(
        .WIDTH(DATA_W), .DEPTH(FIFO_DEPTH), .STOP_LAT(STOP_LAT)
    ) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push_i(in_valid), .data_i(in_data), .pop_i(fifo_pop),
        .data_o(m_wdata), .empty_o(fifo_empty), .ready_o(in_ready)
    );

    strm_burst_ctrl #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .BURST_LEN(BURST_LEN)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .start_i(cmd_start), .base_i(cmd_addr), .count_i(cmd_count),
        .fifo_empty_i(fifo_empty), .awready_i(m_awready), .wready_i(m_wready),
        .bvalid_i(m_bvalid),
        .awvalid_o(m_awvalid), .awaddr_o(m_awaddr), .awlen_o(m_awlen),
        .wvalid_o(m_wvalid), .wlast_o(m_wlast), .bready_o(m_bready),
        .pop_o(fifo_pop), .done_o(done), .idle_o(eng_idle)
    );

endmodule

// File: tb/strm_burst_writer_bench.sv
`timescale 1ns/1ps
module strm_burst_writer_bench;

    localparam int DATA_W = 64;
    localparam int DEPTH  = 16;
    localparam int SLAT   = 4;
    localparam int BLEN   = 4;
    localparam logic [31:0] SEL = 32'h0000_00A5;

    // Vector: {base address[63:32], word count[31:16], stall mode[15:0]}
    localparam int NVEC = 5;
    localparam logic [63:0] VEC [NVEC] = '{
        {32'h0000_1000, 16'd8,  16'd0},
        {32'h0000_2000, 16'd5,  16'd1},
        {32'h0000_3000, 16'd3,  16'd0},
        {32'h0000_4000, 16'd1,  16'd2},
        {32'h0000_5000, 16'd20, 16'd2}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_valid = 1'b0;
    logic [31:0] cfg_data = '0;
    logic in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic in_ready, m_awvalid, m_awready = 1'b0;
    logic [31:0] m_awaddr;
    logic [7:0] m_awlen;
    logic [2:0] m_awsize;
    logic [1:0] m_awburst;
    logic m_wvalid, m_wready = 1'b0, m_wlast, m_bvalid = 1'b0, m_bready, done;
    logic [DATA_W-1:0] m_wdata;
    logic [DATA_W/8-1:0] m_wstrb;

    always #2.5 clk = ~clk;

    strm_burst_writer u_strm_burst_writer (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_data(cfg_data),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
        .m_awlen(m_awlen), .m_awsize(m_awsize), .m_awburst(m_awburst),
        .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata),
        .m_wstrb(m_wstrb), .m_wlast(m_wlast), .m_bvalid(m_bvalid),
        .m_bready(m_bready), .done(done)
    );

    int n_run = 0, n_fail = 0;
    int cyc = 0;
    // Current transfer model.
    bit v_on = 0, started = 0;
    logic [31:0] v_addr = '0;
    int v_cnt = 0, v_mode = 0, v_tag = 0, exp_bursts = 0;
    int sent = 0, bursts_seen = 0, bursts_acked = 0, beats_total = 0;
    int beat_in_burst = 0, cur_len = 0, occ = 0, b_delay = 0;
    bit b_pend = 0, done_pending = 0, vec_complete = 0, late_push = 0, aw_seen = 0;
    int e_addr = 0, e_len = 0, e_data = 0, e_last = 0, e_rdy = 0, e_outst = 0, e_early = 0;
    logic [2:0] rdy_hist = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Memory-side and source model, driven and observed on the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            bit aw_fire, w_fire, b_fire, push;
            logic [31:0] ea;
            int rem, el;
            cyc++;
            if (done_pending) begin
                done_pending = 0;
                chk(done == 1'b1, "R9", "done after final response", done, 1);
                vec_complete = 1;
            end
            if (v_on && started && exp_bursts > 0 && bursts_acked < exp_bursts && done) e_early++;
            if (m_awvalid && m_wvalid) e_outst++;
            if (m_awvalid) aw_seen = 1;
            // R3: ready matches free space seen by the bench
            if (in_ready != ((DEPTH - occ) > SLAT)) e_rdy++;
            // drive memory-side readies
            case (v_mode)
                0: begin m_awready = 1'b1; m_wready = 1'b1; end
                1: begin m_awready = (cyc % 2 == 0); m_wready = (cyc % 3 != 0); end
                default: begin m_awready = (cyc % 3 == 0); m_wready = (cyc % 5 == 0); end
            endcase
            if (b_pend) begin
                if (b_delay > 0) b_delay--;
                m_bvalid = (b_delay == 0);
            end else m_bvalid = 1'b0;
            // source that reacts to ready two cycles late
            rdy_hist = {rdy_hist[1:0], in_ready};
            push = v_on && (sent < v_cnt) && rdy_hist[2] && (v_mode != 1 || cyc % 2 == 0);
            in_valid = push;
            in_data = {32'(v_tag), 32'(sent)};
            if (push) begin
                if (!in_ready) late_push = 1;
                sent++;
            end
            aw_fire = m_awvalid && m_awready;
            w_fire  = m_wvalid && m_wready;
            b_fire  = m_bvalid && m_bready;
            if (aw_fire) begin
                ea  = v_addr + 32'(bursts_seen * 8 * BLEN);
                rem = v_cnt - bursts_seen * BLEN;
                el  = ((rem > BLEN) ? BLEN : rem) - 1;
                if (m_awaddr != ea) begin
                    e_addr++;
                    $display("FAIL R4 burst address: actual=%0h expected=%0h", m_awaddr, ea);
                end
                if (int'(m_awlen) != el || m_awsize != 3'd3 || m_awburst != 2'b01) begin
                    e_len++;
                    $display("FAIL R5 burst length: actual=%0d expected=%0d", m_awlen, el);
                end
                cur_len = int'(m_awlen);
                beat_in_burst = 0;
                bursts_seen++;
            end
            if (w_fire) begin
                if (m_wdata != {32'(v_tag), 32'(beats_total)} || m_wstrb != '1) begin
                    e_data++;
                    $display("FAIL R2 write data: actual=%0h expected=%0h",
                             m_wdata, {32'(v_tag), 32'(beats_total)});
                end
                if (m_wlast != (beat_in_burst == cur_len)) begin
                    e_last++;
                    $display("FAIL R6 wlast: actual=%0d expected=%0d",
                             m_wlast, (beat_in_burst == cur_len));
                end
                beats_total++;
                beat_in_burst++;
                if (m_wlast) begin
                    b_pend = 1;
                    b_delay = (v_mode == 2) ? 3 : 1;
                end
            end
            if (b_fire) begin
                b_pend = 0;
                bursts_acked++;
                if (bursts_acked == exp_bursts) done_pending = 1;
            end
            occ = occ + (push ? 1 : 0) - (w_fire ? 1 : 0);
        end
    end

    task automatic cfg_write(input logic [31:0] d);
        @(negedge clk);
        cfg_valid = 1'b1;
        cfg_data = d;
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    task automatic start_vec(input logic [31:0] a, input int cnt, input int mode, input int tag);
        @(posedge clk);
        v_addr = a; v_cnt = cnt; v_mode = mode; v_tag = tag;
        exp_bursts = (cnt + BLEN - 1) / BLEN;
        sent = 0; bursts_seen = 0; bursts_acked = 0; beats_total = 0;
        late_push = 0; vec_complete = 0; started = 0; aw_seen = 0;
        e_addr = 0; e_len = 0; e_data = 0; e_last = 0; e_rdy = 0; e_outst = 0; e_early = 0;
        v_on = 1;
        cfg_write(SEL);
        cfg_write(a);
        cfg_write(32'(cnt));
        @(negedge clk);
        if (cnt != 0) chk(done == 1'b0, "R9", "done cleared by new command", done, 0);
        else          chk(done == 1'b1, "R9", "zero count sets done", done, 1);
        started = 1;
    endtask

    task automatic finish_vec();
        if (v_cnt != 0) while (!vec_complete) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(bursts_seen == exp_bursts, "R7", "burst count", bursts_seen, exp_bursts);
        chk(beats_total == v_cnt, "R6", "beat count", beats_total, v_cnt);
        chk(sent == v_cnt, "R2", "words delivered", sent, v_cnt);
        chk(e_addr == 0, "R4", "address errors", e_addr, 0);
        chk(e_len == 0, "R5", "length errors", e_len, 0);
        chk(e_data == 0, "R2", "data errors", e_data, 0);
        chk(e_last == 0, "R6", "wlast errors", e_last, 0);
        chk(e_rdy == 0, "R3", "ready threshold errors", e_rdy, 0);
        chk(e_outst == 0, "R7", "overlapped phases", e_outst, 0);
        chk(e_early == 0, "R9", "early done", e_early, 0);
        if (v_cnt >= DEPTH)
            chk(late_push == 1, "R2", "words taken while ready low", late_push, 1);
        v_on = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(done == 1'b0, "R11", "done after reset", done, 0);
        chk(m_awvalid == 1'b0 && m_wvalid == 1'b0 && m_bready == 1'b0, "R11",
            "bus idle after reset", {m_awvalid, m_wvalid, m_bready}, 0);
        chk(in_ready == 1'b1, "R11", "in_ready after reset", in_ready, 1);

        // Table-driven transfers.
        for (int i = 0; i < NVEC; i++) begin
            start_vec(VEC[i][63:32], int'(VEC[i][31:16]), int'(VEC[i][15:0]), i + 1);
            finish_vec();
        end

        // R10: command while busy is discarded.
        start_vec(32'h0000_6000, 12, 2, 6);
        repeat (5) @(negedge clk);
        cfg_write(SEL);
        cfg_write(32'h0000_9000);
        cfg_write(32'd7);
        finish_vec();
        chk(bursts_seen == 3, "R10", "bursts of original command", bursts_seen, 3);

        // R1: writes without the selection code are ignored.
        aw_seen = 0;
        cfg_write(32'h0000_0012);
        cfg_write(32'h0000_7000);
        cfg_write(32'd3);
        repeat (20) @(negedge clk);
        chk(aw_seen == 0, "R1", "no burst without selection", aw_seen, 0);
        chk(done == 1'b1, "R1", "done kept without selection", done, 1);

        // R9: zero count completes with no burst.
        start_vec(32'h0000_7000, 0, 0, 7);
        repeat (10) @(negedge clk);
        chk(aw_seen == 0, "R9", "no burst for zero count", aw_seen, 0);
        finish_vec();

        // R1: a proper sequence still works after stray writes.
        start_vec(32'h0000_8000, 6, 1, 8);
        finish_vec();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule